// File: doc/BRIEF.md
# System control coprocessor unit

This block is the system-control coprocessor that sits next to a small in-order CPU core. Each cycle the core may present one 32-bit coprocessor instruction with `instr_valid` high. The block decodes it and answers in the same cycle with combinational results: read data for a move into a general register, a redirect request with a target address, a branch decision, pulses that tell the core's main loop what to do next, or an illegal-instruction flag. Any register state the instruction changes is updated at the next rising clock edge.

The block holds a bank of 32 system registers and a performance-counter window. The window has one control register and two counter data registers. Moves in both directions are supported. The exception return, interrupt enable and interrupt disable instructions are supported. The coprocessor condition branches are evaluated here. The control path is a single decode step and has no multi-cycle states: `scu_decode` maps the instruction to one of ten operation kinds (MFC, MTC, BF, BT, BFL, TLBWI, ERET, EI, DI, ILL), and the top module turns that kind into outputs and register writes in one cycle.

Top module: `sys_ctrl_cop`

## Requirements
- R1: The format field is bits 25:21. Value 0 moves from the coprocessor, 4 moves to it, 8 is a condition branch and 16 is a coprocessor operation. Any other value drives `illegal` high with no other output active. A move-from raises `gpr_we`.
- R2: For format 16, the function field is bits 5:0. 0x02 is accepted and has no effect. 0x18 is the exception return. 0x38 enables interrupts and 0x39 disables them. Every other function value is illegal.
- R3: After reset every register reads zero, except Status (index 12), which reads 0x00000004 (ERL set).
- R4: For the exception return, if Status bit 2 (ERL) is set, the block redirects to register 30 and clears ERL. Otherwise it redirects to register 14 and clears Status bit 1 (EXL). Both cases pulse `eret_done`.
- R5: A move into index 12 writes the value ORed with the previously stored EXL bit, so EXL cannot be cleared by a move.
- R6: The enable instruction sets Status bit 16 and pulses `int_recheck`. The disable instruction clears bit 16 and does not pulse `int_recheck`.
- R7: For index 25, instruction bit 0 = 0 selects the counter control register. Bit 0 = 1 selects a counter data register, and bit 1 chooses counter 0 or counter 1. This applies to both reads and writes.
- R8: A write to the counter control register stores the value ANDed with 0x800FFBFE, but only when instruction bits 5:1 are all zero. Otherwise the write is dropped.
- R9: With `WIDE_GPR`=1, `rd_data` is 64 bits and bit 31 of the read value is copied into bits 63:32.
- R10: Branches use the rt field (bits 20:16). Value 0 is taken when register 21 is zero. Value 1 is taken when it is nonzero. Value 2 is taken when it is zero and also raises `br_likely`. Other rt values are illegal.
- R11: A move to any index other than 12 and 25 stores the full value, and a move-from returns the stored value unchanged.
- R12: All outputs are valid in the cycle `instr_valid` is high. State changes become visible from the next cycle. With `instr_valid` low, every pulse output is low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Coprocessor instruction word |
| rt_value | input | 32 | Value of the general register named by rt (for moves to the coprocessor) |
| rd_data | output | DW (64 default) | Move-from result, sign-extended when wide |
| gpr_we | output | 1 | Write `rd_data` into general register rt |
| redirect | output | 1 | Exception return redirect request |
| redirect_pc | output | 32 | Redirect target |
| eret_done | output | 1 | Return-from-exception pulse |
| int_recheck | output | 1 | Check pending interrupts pulse |
| br_taken | output | 1 | Condition branch taken |
| br_likely | output | 1 | Likely branch: annul delay slot if not taken |
| illegal | output | 1 | Illegal instruction |

## Verification
Every output is combinational and is due in the same cycle as the instruction. The bench drives each instruction on the falling edge and samples the outputs 1 ns later, before the next rising edge. Register effects take hold at that rising edge, so the bench's reference model applies each instruction's state change right after comparing its outputs. Later instructions in the stream then read the new state: a move-from after a move-to, a branch after writing the condition register, a Status read after a return.

// File: rtl/scu_pkg.sv
package scu_pkg;
    localparam int REG_W       = 32;
    localparam int NUM_REGS    = 32;
    localparam int NUM_CNT     = 2;
    localparam int IDX_STATUS  = 12;
    localparam int IDX_EPC     = 14;
    localparam int IDX_COND    = 21;
    localparam int IDX_PERF    = 25;
    localparam int IDX_ERREPC  = 30;
    localparam int EXL_BIT     = 1;
    localparam int ERL_BIT     = 2;
    localparam int EIE_BIT     = 16;
    localparam logic [REG_W-1:0] CTRL_MASK  = 32'h800F_FBFE;
    localparam logic [REG_W-1:0] STATUS_RST = 32'h1 << ERL_BIT;

    typedef enum logic [3:0] {
        OP_MFC, OP_MTC, OP_BF, OP_BT, OP_BFL,
        OP_TLBWI, OP_ERET, OP_EI, OP_DI, OP_ILL
    } scu_op_e;
endpackage

// File: rtl/scu_decode.sv
module scu_decode
    import scu_pkg::*;
(
    input  logic [25:0] instr,
    output scu_op_e     op
);
    logic [4:0] fmt;
    logic [4:0] rt;
    logic [5:0] fn;

    assign fmt = instr[25:21];
    assign rt  = instr[20:16];
    assign fn  = instr[5:0];

    always_comb begin
        op = OP_ILL;
        unique case (fmt)
            5'd0:  op = OP_MFC;
            5'd4:  op = OP_MTC;
            5'd8: begin
                unique case (rt)
                    5'd0:    op = OP_BF;
                    5'd1:    op = OP_BT;
                    5'd2:    op = OP_BFL;
                    default: op = OP_ILL;
                endcase
            end
            5'd16: begin
                unique case (fn)
                    6'h02:   op = OP_TLBWI;
                    6'h18:   op = OP_ERET;
                    6'h38:   op = OP_EI;
                    6'h39:   op = OP_DI;
                    default: op = OP_ILL;
                endcase
            end
            default: op = OP_ILL;
        endcase
    end
endmodule

// File: rtl/scu_regbank.sv
module scu_regbank
    import scu_pkg::*;
#(
    parameter int W    = REG_W,
    parameter int NREG = NUM_REGS,
    parameter int NCNT = NUM_CNT,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sys_we,
    input  logic [IW-1:0]        sys_widx,
    input  logic [W-1:0]         sys_wdata,
    input  logic                 ctrl_we,
    input  logic [W-1:0]         ctrl_wdata,
    input  logic                 cnt_we,
    input  logic [CW-1:0]        cnt_sel,
    input  logic [W-1:0]         cnt_wdata,
    input  logic [IW-1:0]        ridx,
    output logic [W-1:0]         rdata,
    output logic [W-1:0]         ctrl_q,
    output logic [NCNT-1:0][W-1:0] cnt_q,
    output logic [W-1:0]         status_q,
    output logic [W-1:0]         epc_q,
    output logic [W-1:0]         errepc_q,
    output logic [W-1:0]         cond_q
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [W-1:0] RST = (g == IDX_STATUS) ? STATUS_RST : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= RST;
            else if (sys_we && sys_widx == IW'(g))
                regs[g] <= sys_wdata;
        end
    end

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[c] <= '0;
            else if (cnt_we && cnt_sel == CW'(c))
                cnt_q[c] <= cnt_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_wdata & CTRL_MASK;
    end

    assign rdata    = regs[ridx];
    assign status_q = regs[IDX_STATUS];
    assign epc_q    = regs[IDX_EPC];
    assign errepc_q = regs[IDX_ERREPC];
    assign cond_q   = regs[IDX_COND];
endmodule

// File: rtl/sys_ctrl_cop.sv
module sys_ctrl_cop
    import scu_pkg::*;
#(
    parameter bit  WIDE_GPR = 1'b1,
    localparam int DW       = WIDE_GPR ? 2 * REG_W : REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [31:0]   instr,
    input  logic [31:0]   rt_value,
    output logic [DW-1:0] rd_data,
    output logic          gpr_we,
    output logic          redirect,
    output logic [31:0]   redirect_pc,
    output logic          eret_done,
    output logic          int_recheck,
    output logic          br_taken,
    output logic          br_likely,
    output logic          illegal
);
    localparam logic [REG_W-1:0] EXL_M = REG_W'(1) << EXL_BIT;
    localparam logic [REG_W-1:0] ERL_M = REG_W'(1) << ERL_BIT;
    localparam logic [REG_W-1:0] EIE_M = REG_W'(1) << EIE_BIT;

    scu_op_e             op;
    logic [4:0]          rd;
    logic                sys_we, ctrl_we, cnt_we;
    logic [4:0]          sys_widx;
    logic [REG_W-1:0]    sys_wdata;
    logic [REG_W-1:0]    gen_rdata, ctrl_q, status_q, epc_q, errepc_q, cond_q;
    logic [NUM_CNT-1:0][REG_W-1:0] cnt_q;
    logic [REG_W-1:0]    read_val;

    assign rd = instr[15:11];

    scu_decode u_dec (
        .instr (instr[25:0]),
        .op    (op)
    );

    scu_regbank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_we     (sys_we),
        .sys_widx   (sys_widx),
        .sys_wdata  (sys_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (rt_value),
        .cnt_we     (cnt_we),
        .cnt_sel    (instr[1]),
        .cnt_wdata  (rt_value),
        .ridx       (rd),
        .rdata      (gen_rdata),
        .ctrl_q     (ctrl_q),
        .cnt_q      (cnt_q),
        .status_q   (status_q),
        .epc_q      (epc_q),
        .errepc_q   (errepc_q),
        .cond_q     (cond_q)
    );

    // Read path: index 25 is a window onto the counter block
    always_comb begin
        if (rd == 5'(IDX_PERF))
            read_val = instr[0] ? cnt_q[instr[1]] : ctrl_q;
        else
            read_val = gen_rdata;
    end

    if (WIDE_GPR) begin : g_wide
        assign rd_data = {{REG_W{read_val[REG_W-1]}}, read_val};
    end else begin : g_narrow
        assign rd_data = read_val;
    end

    // Operation outputs and register writes
    always_comb begin
        gpr_we      = 1'b0;
        redirect    = 1'b0;
        redirect_pc = '0;
        eret_done   = 1'b0;
        int_recheck = 1'b0;
        br_taken    = 1'b0;
        br_likely   = 1'b0;
        illegal     = 1'b0;
        sys_we      = 1'b0;
        sys_widx    = rd;
        sys_wdata   = rt_value;
        ctrl_we     = 1'b0;
        cnt_we      = 1'b0;
        if (instr_valid) begin
            unique case (op)
                OP_MFC: gpr_we = 1'b1;
                OP_MTC: begin
                    if (rd == 5'(IDX_PERF)) begin
                        if (instr[0])
                            cnt_we = 1'b1;
                        else
                            ctrl_we = (instr[5:1] == 5'd0);
                    end else begin
                        sys_we = 1'b1;
                        if (rd == 5'(IDX_STATUS))
                            sys_wdata = rt_value | (status_q & EXL_M);
                    end
                end
                OP_BF:  br_taken = (cond_q == '0);
                OP_BT:  br_taken = (cond_q != '0);
                OP_BFL: begin
                    br_taken  = (cond_q == '0);
                    br_likely = 1'b1;
                end
                OP_TLBWI: ;
                OP_ERET: begin
                    redirect  = 1'b1;
                    eret_done = 1'b1;
                    sys_we    = 1'b1;
                    sys_widx  = 5'(IDX_STATUS);
                    if (status_q[ERL_BIT]) begin
                        redirect_pc = errepc_q;
                        sys_wdata   = status_q & ~ERL_M;
                    end else begin
                        redirect_pc = epc_q;
                        sys_wdata   = status_q & ~EXL_M;
                    end
                end
                OP_EI: begin
                    sys_we      = 1'b1;
                    sys_widx    = 5'(IDX_STATUS);
                    sys_wdata   = status_q | EIE_M;
                    int_recheck = 1'b1;
                end
                OP_DI: begin
                    sys_we    = 1'b1;
                    sys_widx  = 5'(IDX_STATUS);
                    sys_wdata = status_q & ~EIE_M;
                end
                default: illegal = 1'b1;
            endcase
        end
    end

    // R1: an illegal instruction produces no other effect
    p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(redirect || br_taken || int_recheck || gpr_we || eret_done));

    // R4: return with ERL set leaves ERL clear
    p_erl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_ERET && status_q[ERL_BIT]) |=> !status_q[ERL_BIT]);

    // R5: EXL survives a move into Status
    p_exl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_MTC && rd == 5'(IDX_STATUS) && status_q[EXL_BIT])
        |=> status_q[EXL_BIT]);

    // R6: enable leaves EIE set
    p_eie_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_EI) |=> status_q[EIE_BIT]);

    // R8: control write with nonzero select bits is dropped
    p_ctrl_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_MTC && rd == 5'(IDX_PERF) && !instr[0] && instr[5:1] != 5'd0)
        |=> $stable(ctrl_q));

    // R12: nothing pulses without an instruction
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !(redirect || br_taken || br_likely || int_recheck || gpr_we
                           || eret_done || illegal));
endmodule

// File: tb/sim_sys_ctrl_cop.sv
module sim_sys_ctrl_cop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rt_value = '0;
    logic [63:0] rd_data;
    logic        gpr_we, redirect, eret_done, int_recheck, br_taken, br_likely, illegal;
    logic [31:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_reg [32];
    logic [31:0] m_ctrl;
    logic [31:0] m_cnt [2];

    always #4 clk = ~clk;

    sys_ctrl_cop u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rt_value(rt_value), .rd_data(rd_data), .gpr_we(gpr_we),
        .redirect(redirect), .redirect_pc(redirect_pc), .eret_done(eret_done),
        .int_recheck(int_recheck), .br_taken(br_taken), .br_likely(br_likely),
        .illegal(illegal)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int fmt, input int rt, input int rd, input int lo);
        return {6'b010000, 5'(fmt), 5'(rt), 5'(rd), 11'(lo)};
    endfunction

    task automatic exec(input logic [31:0] ins, input logic [31:0] gv, input string tag);
        logic [31:0] v;
        bit e_ill = 0, e_red = 0, e_eret = 0, e_chk = 0, e_bt = 0, e_bl = 0, e_gw = 0;
        logic [31:0] e_pc = '0;
        int fmt = int'(ins[25:21]);
        int rt  = int'(ins[20:16]);
        int rd  = int'(ins[15:11]);
        int fn  = int'(ins[5:0]);
        @(negedge clk);
        instr = ins; rt_value = gv; instr_valid = 1'b1;
        #1;
        case (fmt)
            0: begin
                e_gw = 1;
                v = (rd == 25) ? (ins[0] ? m_cnt[ins[1]] : m_ctrl) : m_reg[rd];
                check(rd_data == {{32{v[31]}}, v}, tag, "rd_data", rd_data, {{32{v[31]}}, v});
            end
            4: ;
            8: begin
                if (rt == 0) e_bt = (m_reg[21] == 0);
                else if (rt == 1) e_bt = (m_reg[21] != 0);
                else if (rt == 2) begin e_bt = (m_reg[21] == 0); e_bl = 1; end
                else e_ill = 1;
            end
            16: begin
                if (fn == 'h18) begin
                    e_red = 1; e_eret = 1;
                    e_pc = m_reg[12][2] ? m_reg[30] : m_reg[14];
                end else if (fn == 'h38) e_chk = 1;
                else if (fn != 'h02 && fn != 'h39) e_ill = 1;
            end
            default: e_ill = 1;
        endcase
        check(illegal == e_ill, tag, "illegal", 64'(illegal), 64'(e_ill));
        check(gpr_we == e_gw, tag, "gpr_we", 64'(gpr_we), 64'(e_gw));
        check(redirect == e_red, tag, "redirect", 64'(redirect), 64'(e_red));
        if (e_red) check(redirect_pc == e_pc, tag, "redirect_pc", 64'(redirect_pc), 64'(e_pc));
        check(eret_done == e_eret, tag, "eret_done", 64'(eret_done), 64'(e_eret));
        check(int_recheck == e_chk, tag, "int_recheck", 64'(int_recheck), 64'(e_chk));
        check(br_taken == e_bt, tag, "br_taken", 64'(br_taken), 64'(e_bt));
        check(br_likely == e_bl, tag, "br_likely", 64'(br_likely), 64'(e_bl));
        // model state update, visible from the next cycle
        if (fmt == 4) begin
            if (rd == 25) begin
                if (ins[0]) m_cnt[ins[1]] = gv;
                else if (ins[5:1] == 5'd0) m_ctrl = gv & 32'h800F_FBFE;
            end else if (rd == 12) m_reg[12] = gv | (m_reg[12] & 32'h2);
            else m_reg[rd] = gv;
        end else if (fmt == 16) begin
            if (fn == 'h18) begin
                if (m_reg[12][2]) m_reg[12][2] = 1'b0;
                else m_reg[12][1] = 1'b0;
            end else if (fn == 'h38) m_reg[12][16] = 1'b1;
            else if (fn == 'h39) m_reg[12][16] = 1'b0;
        end
        @(posedge clk);
        #1 instr_valid = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        instr_valid = 1'b0; instr = mk(16, 0, 0, 'h18);
        #1;
        check(!(redirect || br_taken || br_likely || int_recheck || gpr_we || eret_done || illegal),
              tag, "idle pulses", 64'({redirect, br_taken, br_likely, int_recheck, gpr_we, eret_done, illegal}), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_reg[12] = 32'h4;
        m_ctrl = '0; m_cnt[0] = '0; m_cnt[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 and R12: reset state, quiet while idle
        idle_check("R12");
        exec(mk(0, 1, 12, 0), 0, "R3");
        exec(mk(0, 1, 5, 0), 0, "R3");
        exec(mk(0, 1, 25, 1), 0, "R3");
        // R11 and R9: full write, sign-extended read
        exec(mk(4, 1, 7, 0), 32'h8000_1234, "R11");
        exec(mk(0, 1, 7, 0), 0, "R9");
        // R4: return with ERL set, then with EXL
        exec(mk(4, 1, 30, 0), 32'h0000_1000, "R11");
        exec(mk(4, 1, 14, 0), 32'h0000_2000, "R11");
        exec(mk(16, 0, 0, 'h18), 0, "R4");
        exec(mk(0, 1, 12, 0), 0, "R4");
        // R5: EXL cannot be cleared by a move
        exec(mk(4, 1, 12, 0), 32'h2, "R5");
        exec(mk(4, 1, 12, 0), 32'h0, "R5");
        exec(mk(0, 1, 12, 0), 0, "R5");
        exec(mk(16, 0, 0, 'h18), 0, "R4");
        exec(mk(0, 1, 12, 0), 0, "R4");
        // R6: enable / disable
        exec(mk(16, 0, 0, 'h38), 0, "R6");
        exec(mk(0, 1, 12, 0), 0, "R6");
        exec(mk(16, 0, 0, 'h39), 0, "R6");
        exec(mk(0, 1, 12, 0), 0, "R6");
        // R7, R8: counter window
        exec(mk(4, 1, 25, 0), 32'hFFFF_FFFF, "R8");
        exec(mk(0, 1, 25, 0), 0, "R8");
        exec(mk(4, 1, 25, 4), 32'h0, "R8");
        exec(mk(0, 1, 25, 0), 0, "R8");
        exec(mk(4, 1, 25, 1), 32'h11, "R7");
        exec(mk(4, 1, 25, 3), 32'h22, "R7");
        exec(mk(0, 1, 25, 1), 0, "R7");
        exec(mk(0, 1, 25, 3), 0, "R7");
        // R10: branches
        exec(mk(8, 0, 0, 0), 0, "R10");
        exec(mk(8, 1, 0, 0), 0, "R10");
        exec(mk(8, 2, 0, 0), 0, "R10");
        exec(mk(4, 1, 21, 0), 32'h5, "R10");
        exec(mk(8, 0, 0, 0), 0, "R10");
        exec(mk(8, 1, 0, 0), 0, "R10");
        exec(mk(8, 2, 0, 0), 0, "R10");
        exec(mk(8, 3, 0, 0), 0, "R10");
        // R1, R2: formats and functions
        exec(mk(1, 0, 0, 0), 0, "R1");
        exec(mk(31, 0, 0, 0), 0, "R1");
        exec(mk(16, 0, 0, 'h00), 0, "R2");
        exec(mk(16, 0, 0, 'h3A), 0, "R2");
        exec(mk(16, 0, 0, 'h02), 0, "R2");
        idle_check("R12");
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            int k = int'($urandom % 6);
            logic [31:0] r = $urandom;
            case (k)
                0: exec(mk(0, 1, int'(r[4:0]), int'(r[10:0])), 0, "R11");
                1: exec(mk(4, 1, int'(r[4:0]), int'(r[10:0])), $urandom, "R11");
                2: exec(mk(8, int'(r[1:0]), 0, 0), 0, "R10");
                3: exec(mk(16, 0, 0, (r[2:0] == 0) ? 'h18 : (r[2:0] == 1) ? 'h38 :
                           (r[2:0] == 2) ? 'h39 : (r[2:0] == 3) ? 'h02 : int'(r[10:5])), 0, "R2");
                4: exec(mk(int'(r[4:0]), int'(r[9:5]), int'(r[14:10]), int'(r[10:0])), $urandom, "R1");
                default: exec(mk(0, 1, 12, 0), 0, "R5");
            endcase
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule